// File: doc/BRIEF.md
# Variable-Length Packet Transmit Formatter

This block turns a stream of bytes into one serial packet bit by bit. A packet is made of a run of alternating-bit preamble bytes, a 16-bit sync word, an optional length byte, the payload, and an optional two-byte checksum. Data whitening with a 9-bit pseudo-random sequence can be switched on. It then covers the length byte, the payload and the checksum, but never the preamble or the sync word. The serial line moves forward only on cycles where the bit-clock enable is high, so one bit leaves the block for each enable pulse.

In variable-length mode the first byte taken from the input stream is the payload length. This byte is checked before anything is sent. A length of zero, or a length above the programmed limit, discards the byte and raises a reject pulse. In fixed-length mode the programmed limit is the exact payload size and no length byte is sent. If the input stream runs dry while the payload is being sent, the packet is cut short and an underflow pulse is raised.

Top module: `pkt_tx_fmt`

## Requirements
- R1: After reset, ser_out, ser_valid, pkt_done, err_reject and err_underflow are all 0. In fixed mode with no input offered, in_ready is 0.
- R2: ser_out and ser_valid change only on the clock edge that follows a cycle with bit_en high. Each such edge during a packet moves exactly one new bit onto ser_out. Every byte goes out most significant bit first.
- R3: A packet begins with cfg_pre_bytes bytes of value 0xAA (a value of 0 means no preamble). Next comes cfg_sync, high byte first. Neither part is ever whitened.
- R4: Variable mode is selected by cfg_len_mode == 2'b01. In this mode the first input byte L gives the number of payload bytes, not counting itself or the checksum. L is sent right after the sync word and is followed by exactly L payload bytes. L equal to cfg_max_len is accepted.
- R5: In variable mode, a first byte of 0 or a first byte greater than cfg_max_len is consumed and causes a one-cycle err_reject pulse in the following cycle. No bit is sent for it.
- R6: Any other cfg_len_mode value selects fixed mode. A packet starts when in_valid is high and cfg_max_len is non-zero, carries exactly cfg_max_len payload bytes and has no length byte.
- R7: When cfg_crc_en is 1, two checksum bytes follow the payload, high byte first. The checksum is a 16-bit CRC with polynomial 0x8005 and start value 0xFFFF. It is shifted MSB first over the length byte (variable mode only) and the payload, using the data before whitening.
- R8: When cfg_white_en is 1, every bit from the length byte (or the first payload byte in fixed mode) through the last checksum bit is XORed with bit 0 of a 9-bit register. That register is loaded with all ones when the packet starts. After each of these bits it shifts right, and bit 8 takes the XOR of bits 0 and 5 (x^9 + x^5 + 1).
- R9: If a payload byte is needed and in_valid is low, the packet stops after the byte in flight. err_underflow pulses together with the last bit sent, and no further bit is sent.
- R10: One byte is taken per cycle with in_valid and in_ready both high. in_ready is high only while idle in variable mode, or on a bit_en cycle where the next payload byte is due. Every byte offered for a packet is consumed and no more.
- R11: pkt_done pulses for one cycle at the same time as the final bit of a complete packet appears on ser_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable, one serial bit per high cycle |
| in_data | input | 8 | Input byte (length byte first in variable mode) |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Byte is taken this cycle if in_valid is high |
| cfg_len_mode | input | 2 | 2'b01 selects variable length, other values select fixed length |
| cfg_max_len | input | 8 | Largest length (variable mode) or exact length (fixed mode) |
| cfg_crc_en | input | 1 | Append a two-byte checksum |
| cfg_white_en | input | 1 | Whiten everything after the sync word |
| cfg_pre_bytes | input | PRE_W | Number of 0xAA preamble bytes |
| cfg_sync | input | 16 | Sync word |
| ser_out | output | 1 | Serial data |
| ser_valid | output | 1 | ser_out holds a packet bit |
| pkt_done | output | 1 | Pulse with the final bit of a complete packet |
| err_reject | output | 1 | Pulse after an illegal length byte |
| err_underflow | output | 1 | Pulse when a packet is cut short by an empty input |

## Verification
A serial bit is due on the clock edge right after each bit_en cycle. The bench therefore records bit_en at every rising edge and compares ser_out against its queue at the next falling edge. pkt_done and err_underflow are due on the same edge as the last bit sent, so they are checked at that same falling edge against an empty queue. err_reject is due one edge after its byte is taken. The input handshake is decided at the falling edge, where the bench samples in_ready one step after driving in_valid and in_data. A byte is removed from the input queue only when that sample showed a transfer at the following rising edge.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
    localparam int          BYTE_W      = 8;
    localparam int          SYNC_W      = 16;
    localparam logic [7:0]  PRE_PATTERN = 8'hAA;
    localparam logic [1:0]  MODE_VAR    = 2'b01;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SYNC,
        PH_LEN,
        PH_PAY,
        PH_CRC
    } phase_e;
endpackage

// File: rtl/pkt_tx_crc16.sv
module pkt_tx_crc16 #(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = 16'h8005,
    parameter logic [15:0] INIT  = 16'hFFFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       step,
    input  logic       bit_in,
    output logic [7:0] hi_next,
    output logic [7:0] lo_now
);
    localparam int HALF = CRC_W / 2;

    logic [CRC_W-1:0] crc_d, crc_q, crc_upd;
    logic             fb;

    always_comb begin
        fb      = crc_q[CRC_W-1] ^ bit_in;
        crc_upd = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        crc_d   = crc_q;
        if (init)      crc_d = INIT;
        else if (step) crc_d = crc_upd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    assign hi_next = crc_upd[CRC_W-1 -: HALF];
    assign lo_now  = crc_q[HALF-1:0];

    // R7
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(step) && !$past(init)) |-> $stable(crc_q));
endmodule

// File: rtl/pkt_tx_pn9.sv
module pkt_tx_pn9 #(
    parameter int LFSR_W = 9,
    parameter int TAP    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed,
    input  logic step,
    output logic pn_bit
);
    logic [LFSR_W-1:0] pn_d, pn_q;

    always_comb begin
        pn_d = pn_q;
        if (seed)      pn_d = '1;
        else if (step) pn_d = {pn_q[0] ^ pn_q[TAP], pn_q[LFSR_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pn_q <= '1;
        else        pn_q <= pn_d;
    end

    assign pn_bit = pn_q[0];

    // R8
    pn_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pn_q != '0);
endmodule

// File: rtl/pkt_tx_fmt.sv
module pkt_tx_fmt
    import pkt_tx_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       cfg_len_mode,
    input  logic [7:0]       cfg_max_len,
    input  logic             cfg_crc_en,
    input  logic             cfg_white_en,
    input  logic [PRE_W-1:0] cfg_pre_bytes,
    input  logic [15:0]      cfg_sync,
    output logic             ser_out,
    output logic             ser_valid,
    output logic             pkt_done,
    output logic             err_reject,
    output logic             err_underflow
);
    localparam int BIDX_W = $clog2(BYTE_W);
    localparam logic [BIDX_W-1:0] TOP_BIT = BIDX_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e            ph;
        logic [7:0]        sh;
        logic [BIDX_W-1:0] bidx;
        logic [PRE_W-1:0]  pre_left;
        logic              half;
        logic [7:0]        len;
        logic [7:0]        rem;
        logic              out;
        logic              vld;
        logic              done;
        logic              rej;
        logic              uf;
    } st_t;

    st_t        st_d, st_q;
    logic       crc_init, crc_step, pn_seed, pn_step, pn_bit;
    logic [7:0] crc_hi_nx, crc_lo;
    logic       var_mode;

    assign var_mode = (cfg_len_mode == MODE_VAR);

    pkt_tx_crc16 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (crc_init),
        .step    (crc_step),
        .bit_in  (st_q.sh[st_q.bidx]),
        .hi_next (crc_hi_nx),
        .lo_now  (crc_lo)
    );

    pkt_tx_pn9 u_pn9 (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed   (pn_seed),
        .step   (pn_step),
        .pn_bit (pn_bit)
    );

    always_comb begin
        logic       raw_bit, white_ph, want_fetch, want_tail, go_start;
        logic [7:0] start_len, rem_base;

        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.rej   = 1'b0;
        st_d.uf    = 1'b0;
        in_ready   = 1'b0;
        crc_init   = 1'b0;
        crc_step   = 1'b0;
        pn_seed    = 1'b0;
        pn_step    = 1'b0;
        want_fetch = 1'b0;
        want_tail  = 1'b0;
        go_start   = 1'b0;
        start_len  = '0;
        raw_bit    = st_q.sh[st_q.bidx];
        white_ph   = (st_q.ph == PH_LEN) || (st_q.ph == PH_PAY) || (st_q.ph == PH_CRC);
        rem_base   = (st_q.ph == PH_PAY) ? st_q.rem : st_q.len;

        if (st_q.ph == PH_IDLE) begin
            if (bit_en) begin
                st_d.out = 1'b0;
                st_d.vld = 1'b0;
            end
            if (var_mode) begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (in_data == 8'd0 || in_data > cfg_max_len) begin
                        st_d.rej = 1'b1;
                    end else begin
                        go_start  = 1'b1;
                        start_len = in_data;
                    end
                end
            end else if (in_valid && cfg_max_len != 8'd0) begin
                go_start  = 1'b1;
                start_len = cfg_max_len;
            end
        end else if (bit_en) begin
            st_d.out = raw_bit ^ (white_ph & cfg_white_en & pn_bit);
            st_d.vld = 1'b1;
            pn_step  = white_ph;
            crc_step = (st_q.ph == PH_LEN) || (st_q.ph == PH_PAY);
            if (st_q.bidx != '0) begin
                st_d.bidx = st_q.bidx - 1'b1;
            end else begin
                st_d.bidx = TOP_BIT;
                unique case (st_q.ph)
                    PH_PRE: begin
                        if (st_q.pre_left != '0) begin
                            st_d.pre_left = st_q.pre_left - 1'b1;
                            st_d.sh       = PRE_PATTERN;
                        end else begin
                            st_d.ph   = PH_SYNC;
                            st_d.half = 1'b0;
                            st_d.sh   = cfg_sync[15:8];
                        end
                    end
                    PH_SYNC: begin
                        if (!st_q.half) begin
                            st_d.half = 1'b1;
                            st_d.sh   = cfg_sync[7:0];
                        end else if (var_mode) begin
                            st_d.ph = PH_LEN;
                            st_d.sh = st_q.len;
                        end else begin
                            want_fetch = 1'b1;
                        end
                    end
                    PH_LEN: want_fetch = 1'b1;
                    PH_PAY: begin
                        if (st_q.rem != 8'd0) want_fetch = 1'b1;
                        else                  want_tail  = 1'b1;
                    end
                    PH_CRC: begin
                        if (!st_q.half) begin
                            st_d.half = 1'b1;
                            st_d.sh   = crc_lo;
                        end else begin
                            st_d.ph   = PH_IDLE;
                            st_d.done = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end

        if (want_fetch) begin
            in_ready = 1'b1;
            if (in_valid) begin
                st_d.ph  = PH_PAY;
                st_d.sh  = in_data;
                st_d.rem = rem_base - 8'd1;
            end else begin
                st_d.ph = PH_IDLE;
                st_d.uf = 1'b1;
            end
        end

        if (want_tail) begin
            if (cfg_crc_en) begin
                st_d.ph   = PH_CRC;
                st_d.half = 1'b0;
                st_d.sh   = crc_hi_nx;
            end else begin
                st_d.ph   = PH_IDLE;
                st_d.done = 1'b1;
            end
        end

        if (go_start) begin
            crc_init  = 1'b1;
            pn_seed   = 1'b1;
            st_d.len  = start_len;
            st_d.bidx = TOP_BIT;
            if (cfg_pre_bytes != '0) begin
                st_d.ph       = PH_PRE;
                st_d.pre_left = cfg_pre_bytes - 1'b1;
                st_d.sh       = PRE_PATTERN;
            end else begin
                st_d.ph   = PH_SYNC;
                st_d.half = 1'b0;
                st_d.sh   = cfg_sync[15:8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_IDLE;
            st_q.bidx <= TOP_BIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out       = st_q.out;
    assign ser_valid     = st_q.vld;
    assign pkt_done      = st_q.done;
    assign err_reject    = st_q.rej;
    assign err_underflow = st_q.uf;

    // R2
    ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> ($stable(ser_out) && $stable(ser_valid)));
    // R5
    reject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_reject |-> $past(in_valid && in_ready));
    // R9
    uf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> (!pkt_done && !err_reject && $past(bit_en)));
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);
endmodule

// File: tb/pkt_tx_fmt_tb_top.sv
`timescale 1ns/100ps
module pkt_tx_fmt_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  cfg_len_mode = 2'b00;
    logic [7:0]  cfg_max_len = 8'd8;
    logic        cfg_crc_en = 1'b0;
    logic        cfg_white_en = 1'b0;
    logic [3:0]  cfg_pre_bytes = 4'd2;
    logic [15:0] cfg_sync = 16'hD391;
    logic        ser_out, ser_valid, pkt_done, err_reject, err_underflow;

    always #2.5 clk = ~clk;

    pkt_tx_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .cfg_len_mode(cfg_len_mode), .cfg_max_len(cfg_max_len),
        .cfg_crc_en(cfg_crc_en), .cfg_white_en(cfg_white_en),
        .cfg_pre_bytes(cfg_pre_bytes), .cfg_sync(cfg_sync),
        .ser_out(ser_out), .ser_valid(ser_valid), .pkt_done(pkt_done),
        .err_reject(err_reject), .err_underflow(err_underflow)
    );

    int         n_tests = 0, n_fail = 0;
    int         done_cnt = 0, rej_cnt = 0, uf_cnt = 0;
    bit         exp_q[$];
    logic [7:0] in_q[$];
    logic [7:0] pl_q[$];
    string      cur_req = "R1";
    bit         en_seen = 1'b0;
    bit         hs = 1'b0;
    logic [8:0]  pn_m;
    logic [15:0] crc_m;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // input driver: bit enable every third cycle, byte queue with handshake
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            if (hs && in_q.size() > 0) in_q.delete(0);
            hs       = 1'b0;
            bit_en   = rst_n && (div == 0);
            div      = (div == 2) ? 0 : div + 1;
            in_valid = (in_q.size() != 0);
            in_data  = in_valid ? in_q[0] : 8'h00;
            #1;
            hs = in_valid && in_ready && rst_n;
        end
    end

    always @(posedge clk) en_seen <= bit_en;

    // monitor: pops expected bits as they appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (en_seen && ser_valid) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, cur_req, "unexpected bit", ser_out, 0);
                    end else begin
                        bit eb;
                        eb = exp_q.pop_front();
                        chk(ser_out === eb, cur_req, "serial bit", ser_out, eb);
                    end
                end
                if (pkt_done) begin
                    done_cnt++;
                    chk(exp_q.size() == 0, "R11", "bits pending at done", exp_q.size(), 0);
                end
                if (err_underflow) begin
                    uf_cnt++;
                    chk(exp_q.size() == 0, "R9", "bits pending at underflow", exp_q.size(), 0);
                end
                if (err_reject) rej_cnt++;
            end
        end
    end

    task automatic put_byte(input logic [7:0] b, input bit wz, input bit cz);
        for (int i = 7; i >= 0; i--) begin
            bit raw, w, fb;
            raw = b[i];
            w   = raw;
            if (wz) begin
                if (cfg_white_en) w = raw ^ pn_m[0];
                pn_m = {pn_m[0] ^ pn_m[5], pn_m[8:1]};
            end
            if (cz) begin
                fb    = crc_m[15] ^ raw;
                crc_m = {crc_m[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
            end
            exp_q.push_back(w);
        end
    endtask

    task automatic run_pkt(input string req, input bit varm, input int supply);
        int L, d0, u0;
        bit full;
        logic [15:0] c;
        cfg_len_mode = varm ? 2'b01 : 2'b00;
        L    = varm ? pl_q.size() : int'(cfg_max_len);
        if (varm) supply = L;
        full = (supply >= L);
        pn_m  = '1;
        crc_m = '1;
        for (int i = 0; i < int'(cfg_pre_bytes); i++) put_byte(8'hAA, 1'b0, 1'b0);
        put_byte(cfg_sync[15:8], 1'b0, 1'b0);
        put_byte(cfg_sync[7:0], 1'b0, 1'b0);
        if (varm) put_byte(8'(L), 1'b1, 1'b1);
        for (int i = 0; i < supply; i++) put_byte(pl_q[i], 1'b1, 1'b1);
        if (full && cfg_crc_en) begin
            c = crc_m;
            put_byte(c[15:8], 1'b1, 1'b0);
            put_byte(c[7:0], 1'b1, 1'b0);
        end
        d0 = done_cnt;
        u0 = uf_cnt;
        cur_req = req;
        if (varm) in_q.push_back(8'(L));
        for (int i = 0; i < supply; i++) in_q.push_back(pl_q[i]);
        for (int k = 0; k < 20000 && (done_cnt + uf_cnt) == (d0 + u0); k++) @(negedge clk);
        repeat (12) @(negedge clk);
        chk((done_cnt - d0) == (full ? 1 : 0), "R11", "done pulses", done_cnt - d0, full ? 1 : 0);
        chk((uf_cnt - u0) == (full ? 0 : 1), "R9", "underflow pulses", uf_cnt - u0, full ? 0 : 1);
        chk(exp_q.size() == 0, req, "bits never sent", exp_q.size(), 0);
        chk(in_q.size() == 0, "R10", "bytes not consumed", in_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic run_reject(input string req, input logic [7:0] lb);
        int r0;
        cfg_len_mode = 2'b01;
        cur_req = req;
        r0 = rej_cnt;
        in_q.push_back(lb);
        repeat (12) @(negedge clk);
        chk((rej_cnt - r0) == 1, req, "reject pulses", rej_cnt - r0, 1);
        chk(in_q.size() == 0, req, "bad length byte not consumed", in_q.size(), 0);
        chk(!ser_valid, req, "line active after reject", ser_valid, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ser_out == 1'b0, "R1", "ser_out", ser_out, 0);
        chk(ser_valid == 1'b0, "R1", "ser_valid", ser_valid, 0);
        chk(in_ready == 1'b0, "R1", "in_ready", in_ready, 0);
        chk(!pkt_done && !err_reject && !err_underflow, "R1", "flags", 1, 0);

        // R4 R7 R3 R2: variable length, checksum, no whitening
        cfg_crc_en = 1'b1; cfg_white_en = 1'b0; cfg_pre_bytes = 4'd2; cfg_max_len = 8'd8;
        pl_q = '{8'h11, 8'h22, 8'h33};
        run_pkt("R4", 1'b1, 0);

        // R8 whitening with checksum, variable length
        cfg_white_en = 1'b1; cfg_pre_bytes = 4'd3; cfg_sync = 16'h2DD4;
        pl_q = '{8'h00, 8'hFF, 8'h5A, 8'hC3, 8'h01};
        run_pkt("R8", 1'b1, 0);

        // R6 R3 fixed length, no preamble, no checksum, no whitening
        cfg_crc_en = 1'b0; cfg_white_en = 1'b0; cfg_pre_bytes = 4'd0; cfg_max_len = 8'd3;
        pl_q = '{8'h80, 8'h7E, 8'h01};
        run_pkt("R6", 1'b0, 3);

        // R6 R7 R8 fixed length with checksum and whitening
        cfg_crc_en = 1'b1; cfg_white_en = 1'b1; cfg_pre_bytes = 4'd1; cfg_max_len = 8'd4;
        pl_q = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
        run_pkt("R7", 1'b0, 4);

        // R5 illegal lengths, then R4 boundary length equal to the limit
        cfg_max_len = 8'd8;
        run_reject("R5", 8'h00);
        run_reject("R5", 8'h09);
        cfg_white_en = 1'b0;
        pl_q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
        run_pkt("R4", 1'b1, 0);

        // R9 payload underflow in fixed mode
        cfg_white_en = 1'b1; cfg_max_len = 8'd4; cfg_pre_bytes = 4'd1;
        pl_q = '{8'hA5, 8'h3C};
        run_pkt("R9", 1'b0, 2);

        // R2 R7 single payload byte, variable mode
        cfg_crc_en = 1'b1; cfg_white_en = 1'b0;
        pl_q = '{8'h96};
        run_pkt("R2", 1'b1, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule